// File: doc/BRIEF.md
# Instruction Fetch Next-PC Unit

This block holds the program counter of a simple single-cycle processor and picks the counter's next value on every clock edge. The program counter addresses a byte-addressed instruction memory. The word the memory returns for the current address goes to two places. Its low fields supply the branch offset and the jump address for the next-address choice. The same word is captured into a 32-bit instruction register.

The next address is chosen from four candidates:
- **Sequential step:** the address of the following word.
- **Relative branch:** a conditional branch, taken only when the external branch control and the arithmetic unit's zero flag are both high.
- **Region jump:** an unconditional jump that keeps the top four bits of the step address and fills the rest from a 26-bit word address.
- **Register jump:** a jump that loads a full 32-bit register value from the datapath.

The step address is also driven out so that decode and execute logic can use it. Decode and execution sit outside this block. The control inputs are taken to describe the word being fetched in the current cycle.

Top module: `fetch_npc`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_o` becomes 0 and `ir_o` becomes 0 (synchronous, active-high reset).
- R2: `pc_plus4_o` always equals `pc_o + 4`, modulo 2^32. With no register jump, no region jump and no taken branch, the next `pc_o` is `pc_o + 4`.
- R3: At every rising edge out of reset, `ir_o` takes the value that `imem_rdata` held before that edge.
- R4: When `br_en` and `alu_zero` are both 1, and neither jump select is 1, the next `pc_o` is `pc_o + 4` plus the sign-extended `imem_rdata[15:0]` shifted left by 2.
- R5: A branch is not taken unless both `br_en` and `alu_zero` are 1. If either is 0, with no jump selected, the next `pc_o` is `pc_o + 4`.
- R6: When `jmp_sel` is 1 and `jr_sel` is 0, the next `pc_o` is {`pc_plus4_o[31:28]`, `imem_rdata[25:0]`, 2'b00}. This holds whatever `br_en` and `alu_zero` are.
- R7: When `jr_sel` is 1, the next `pc_o` is `reg_val`, regardless of `jmp_sel`, `br_en` and `alu_zero`.
- R8: A negative branch offset moves the counter backwards. An offset field of 16'hFFFE from address A gives A + 4 - 8 = A - 4.
- R9: The top four bits of a region jump come from `pc_o + 4`, not from `pc_o`. From `pc_o` = 32'h0FFFFFFC, a jump with word address 5 gives 32'h10000014.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_rdata | input | 32 | Instruction word returned for the current `pc_o` |
| br_en | input | 1 | Current word is a conditional branch |
| alu_zero | input | 1 | Zero flag from the arithmetic unit |
| jmp_sel | input | 1 | Take the region jump |
| jr_sel | input | 1 | Take the register jump |
| reg_val | input | 32 | Register value used by the register jump |
| pc_o | output | 32 | Program counter, also the instruction memory address |
| ir_o | output | 32 | Instruction register |
| pc_plus4_o | output | 32 | Program counter plus 4 |

## Verification
The program counter and the instruction register both change at the first rising edge after their inputs are applied. `pc_plus4_o` follows `pc_o` combinationally, with no added delay. The bench changes its inputs away from the edges. It then waits for one rising edge and samples 1 ns after it. At that point the new counter, the captured word and the step address are all due together. The instruction memory is a bench array read at the current counter address, so the fields that steer each choice are present in the same cycle as the control inputs.

// File: rtl/fetch_npc.sv
module fetch_npc #(
  parameter int unsigned REG_W = 32,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned JA_W  = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] imem_rdata,
  input  logic             br_en,
  input  logic             alu_zero,
  input  logic             jmp_sel,
  input  logic             jr_sel,
  input  logic [REG_W-1:0] reg_val,
  output logic [REG_W-1:0] pc_o,
  output logic [REG_W-1:0] ir_o,
  output logic [REG_W-1:0] pc_plus4_o
);
  localparam int unsigned SEXT_W = REG_W - OFF_W - 2;
  localparam int unsigned REGN_W = REG_W - JA_W - 2;

  logic [REG_W-1:0] pc_q, ir_q, pc_nxt;
  logic [REG_W-1:0] br_tgt, jmp_tgt;
  logic             br_take;

  assign pc_plus4_o = pc_q + REG_W'(4);
  assign br_take    = br_en & alu_zero;
  assign br_tgt     = pc_plus4_o +
                      {{SEXT_W{imem_rdata[OFF_W-1]}}, imem_rdata[OFF_W-1:0], 2'b00};
  assign jmp_tgt    = {pc_plus4_o[REG_W-1 -: REGN_W], imem_rdata[JA_W-1:0], 2'b00};

  always_comb begin
    if (jr_sel)       pc_nxt = reg_val;
    else if (jmp_sel) pc_nxt = jmp_tgt;
    else if (br_take) pc_nxt = br_tgt;
    else              pc_nxt = pc_plus4_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      pc_q <= pc_nxt;
      ir_q <= imem_rdata;
    end
  end

  assign pc_o = pc_q;
  assign ir_o = ir_q;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pc_o == '0 && ir_o == '0));

  // R3
  ir_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ir_o == $past(imem_rdata));

  // R7
  reg_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (jr_sel && !rst) |=> pc_o == $past(reg_val));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !jr_sel && !jmp_sel && !(br_en && alu_zero)) |=> pc_o == $past(pc_o) + REG_W'(4));

  // R6
  jump_region_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !jr_sel && jmp_sel) |=>
      (pc_o[1:0] == 2'b00 &&
       pc_o[REG_W-1 -: REGN_W] == $past(pc_plus4_o[REG_W-1 -: REGN_W])));

  // R4
  branch_align_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !jr_sel && !jmp_sel && br_en && alu_zero) |=>
      pc_o[1:0] == $past(pc_o[1:0]));
endmodule

// File: tb/fetch_npc_tb.sv
`timescale 1ns/1ps
module fetch_npc_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] imem_rdata;
  logic        br_en, alu_zero, jmp_sel, jr_sel;
  logic [31:0] reg_val;
  logic [31:0] pc_o, ir_o, pc_plus4_o;

  logic [31:0] mem [0:255];
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  assign imem_rdata = mem[pc_o[9:2]];

  fetch_npc dut_i (
    .clk(clk), .rst(rst), .imem_rdata(imem_rdata),
    .br_en(br_en), .alu_zero(alu_zero), .jmp_sel(jmp_sel), .jr_sel(jr_sel),
    .reg_val(reg_val), .pc_o(pc_o), .ir_o(ir_o), .pc_plus4_o(pc_plus4_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ctl(input logic b, input logic z, input logic j, input logic r, input logic [31:0] v);
    br_en = b; alu_zero = z; jmp_sel = j; jr_sel = r; reg_val = v;
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic put(input logic [31:0] w);
    mem[pc_o[9:2]] = w;
  endtask

  task automatic goto(input logic [31:0] a);
    ctl(0, 0, 0, 1, a); step; ctl(0, 0, 0, 0, 0);
  endtask

  task automatic t_reset;
    rst = 1'b1; ctl(1, 1, 1, 1, 32'h1234_5678); step;
    chk("R1 pc", pc_o, 32'h0);
    chk("R1 ir", ir_o, 32'h0);
    chk("R2 pc_plus4 after reset", pc_plus4_o, 32'h4);
    rst = 1'b0; ctl(0, 0, 0, 0, 0);
  endtask

  task automatic t_seq;
    logic [31:0] w, p;
    for (int i = 0; i < 3; i++) begin
      p = pc_o; w = 32'hA000_0000 + i; put(w); step;
      chk("R2 seq pc", pc_o, p + 4);
      chk("R3 ir capture", ir_o, w);
      chk("R2 pc_plus4", pc_plus4_o, p + 8);
    end
  endtask

  task automatic t_branch_fwd;
    logic [31:0] p;
    goto(32'h0000_0100); p = pc_o; put(32'h1000_0003);
    ctl(1, 1, 0, 0, 0); step;
    chk("R4 forward branch", pc_o, p + 4 + 12);
    ctl(0, 0, 0, 0, 0);
  endtask

  task automatic t_branch_not;
    logic [31:0] p;
    p = pc_o; put(32'h1000_0010); ctl(1, 0, 0, 0, 0); step;
    chk("R5 branch zero=0", pc_o, p + 4);
    p = pc_o; put(32'h1000_0010); ctl(0, 1, 0, 0, 0); step;
    chk("R5 zero without branch", pc_o, p + 4);
    ctl(0, 0, 0, 0, 0);
  endtask

  task automatic t_branch_back;
    logic [31:0] p;
    goto(32'h0000_0200); p = pc_o; put(32'h1000_FFFE);
    ctl(1, 1, 0, 0, 0); step;
    chk("R8 backward branch", pc_o, p - 4);
    p = pc_o; put(32'h1000_8000); step;
    chk("R8 most negative offset", pc_o, p + 4 - 32'h0002_0000);
    ctl(0, 0, 0, 0, 0);
  endtask

  task automatic t_jump;
    goto(32'h3000_0040); put(32'h0800_0010);
    ctl(1, 1, 1, 0, 0); step;
    chk("R6 jump over branch", pc_o, 32'h3000_0040);
    put(32'h0BFF_FFFF); ctl(0, 0, 1, 0, 0); step;
    chk("R6 jump full field", pc_o, 32'h3FFF_FFFC);
    ctl(0, 0, 0, 0, 0);
  endtask

  task automatic t_region;
    goto(32'h0FFF_FFFC); put(32'h0800_0005);
    ctl(0, 0, 1, 0, 0); step;
    chk("R9 region from pc+4", pc_o, 32'h1000_0014);
    ctl(0, 0, 0, 0, 0);
  endtask

  task automatic t_jr;
    put(32'h0800_0001); ctl(1, 1, 1, 1, 32'hDEAD_BEE0); step;
    chk("R7 register jump wins", pc_o, 32'hDEAD_BEE0);
    ctl(0, 0, 0, 1, 32'hFFFF_FFFC); step;
    chk("R7 register jump top", pc_o, 32'hFFFF_FFFC);
    ctl(0, 0, 0, 0, 0);
    chk("R2 pc_plus4 wrap", pc_plus4_o, 32'h0);
    step;
    chk("R2 wrap step", pc_o, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    rst = 1'b1; ctl(0, 0, 0, 0, 0);
    @(negedge clk);
    t_reset;
    t_seq;
    t_branch_fwd;
    t_branch_not;
    t_branch_back;
    t_jump;
    t_region;
    t_jr;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule